// File: doc/BRIEF.md
# Key-Protected Software Reset Pulse Generator

This block holds a write-only reset command bit inside a control register. When a qualifying register write sets the bit, the block drives two active-low reset outputs low for a programmed number of clock cycles and then releases them. One output is for the host processor and the other is for its memory. The two outputs always move in the same cycle.

The command is guarded by a security key. A separate key-write port unlocks the command when it receives one constant value. Any other value written there locks the command again. While the command is locked, a write that sets the command bit does nothing. The command bit clears itself after it fires, so software never has to clear it.

The pulse length is latched when the command fires. A command that arrives while a pulse is running neither restarts the pulse nor lengthens it.

Top module: `keyed_reset_pulser`

## Requirements
- R1: After `rst_n` is released, `cpu_rst_n` and `mem_rst_n` are both 1 and the key is locked.
- R2: A write to the command register with bit 14 of `wr_data` equal to 0 starts no pulse, whatever the other data bits are.
- R3: A command write made while the key is locked is ignored, and no pulse follows it.
- R4: An accepted command drives both outputs to 0 starting in the cycle after the write strobe. They stay at 0 for exactly `dur` cycles; a `dur` of 0 gives a 1-cycle pulse.
- R5: `cpu_rst_n` and `mem_rst_n` are equal in every cycle.
- R6: A key write with value 16'hA5C3 unlocks the key, and any other key value locks it. The unlocked state persists across accepted commands until the next key write.
- R7: Only writes to address 3 with bit 14 of `wr_data` set act as a command. The same data written to any other address has no effect.
- R8: While a pulse is active, a further command write does not restart or extend it. A change of `dur` during the pulse does not change its length.
- R9: When a key write and a command write fall in the same cycle, the command is judged against the key state that held before that key write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | 16 | Register write data |
| key_wr | input | 1 | Key write strobe |
| key_data | input | 16 | Key value |
| dur | input | DUR_W | Programmed pulse length in cycles |
| cpu_rst_n | output | 1 | Processor reset, active low |
| mem_rst_n | output | 1 | Memory reset, active low |

## Verification
Two functions can fall in the same cycle: a key write can coincide with a command write, and a command write can arrive while a pulse is already running.

The bench provokes the first case in both directions:
- an unlocking key arrives together with a command while the key is locked, and no pulse is expected;
- a locking key arrives together with a command while the key is unlocked, and a pulse is expected.

For the second case, the bench injects a command part-way through a pulse and also changes `dur` in that cycle. It then requires the measured low time to equal the originally latched length.

// File: rtl/keyed_reset_pulser.sv
module keyed_reset_pulser #(
  parameter int          ADDR_W   = 8,
  parameter int          DUR_W    = 8,
  parameter int          CMD_ADDR = 3,
  parameter int          CMD_BIT  = 14,
  parameter logic [15:0] KEY_VAL  = 16'hA5C3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [15:0]       wr_data,
  input  logic              key_wr,
  input  logic [15:0]       key_data,
  input  logic [DUR_W-1:0]  dur,
  output logic              cpu_rst_n,
  output logic              mem_rst_n
);

  localparam logic [ADDR_W-1:0] CmdAddr = ADDR_W'(CMD_ADDR);
  localparam logic [DUR_W-1:0]  One     = DUR_W'(1);

  logic             unlocked;
  logic [DUR_W-1:0] cnt;
  logic             cmd_hit, fire, last;
  logic [DUR_W-1:0] dur_eff;

  assign cmd_hit = wr_en && (wr_addr == CmdAddr) && wr_data[CMD_BIT];
  assign fire    = cmd_hit && unlocked && cpu_rst_n;
  assign last    = !cpu_rst_n && (cnt == One);
  assign dur_eff = (dur == '0) ? One : dur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      unlocked <= 1'b0;
    else if (key_wr) unlocked <= (key_data == KEY_VAL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (fire)      cnt <= dur_eff;
    else if (!cpu_rst_n) cnt <= cnt - One;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_rst_n <= 1'b1;
      mem_rst_n <= 1'b1;
    end else if (fire) begin
      cpu_rst_n <= 1'b0;
      mem_rst_n <= 1'b0;
    end else if (last) begin
      cpu_rst_n <= 1'b1;
      mem_rst_n <= 1'b1;
    end
  end

  // R5
  a_r5_together: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rst_n == mem_rst_n);

  // R3
  a_r3_locked_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_hit && !unlocked && cpu_rst_n) |=> cpu_rst_n);

  // R2
  a_r2_zero_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[CMD_BIT] && cpu_rst_n) |=> cpu_rst_n);

  // R4
  a_r4_start: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_hit && unlocked && cpu_rst_n) |=> !mem_rst_n);

  // R8
  a_r8_no_extend: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_rst_n && cnt == One) |=> cpu_rst_n);

endmodule

// File: tb/keyed_reset_pulser_test.sv
module keyed_reset_pulser_test;
  logic        clk = 0, rst_n = 0;
  logic        wr_en = 0, key_wr = 0;
  logic [7:0]  wr_addr = 0, dur = 0;
  logic [15:0] wr_data = 0, key_data = 0;
  logic        cpu_rst_n, mem_rst_n;
  int n_chk = 0, n_bad = 0;

  localparam logic [15:0] KEY = 16'hA5C3;
  localparam logic [15:0] CMD = 16'h4000;

  keyed_reset_pulser uut (.*);

  always #2 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One write cycle (register and/or key), then measure the low time.
  task automatic run(input logic do_wr, input logic [7:0] a, input logic [15:0] d,
                     input logic do_key, input logic [15:0] k,
                     input int retrig_at, output int len);
    @(negedge clk);
    wr_en = do_wr; wr_addr = a; wr_data = d; key_wr = do_key; key_data = k;
    @(negedge clk);
    wr_en = 0; key_wr = 0;
    len = 0;
    while (len < 300) begin
      if (cpu_rst_n !== mem_rst_n) chk("R5", mem_rst_n, cpu_rst_n);
      if (cpu_rst_n) break;
      len++;
      if (len == retrig_at) begin
        wr_en = 1; wr_addr = 3; wr_data = CMD; dur = dur + 8'd5;
      end else wr_en = 0;
      @(negedge clk);
    end
    wr_en = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic key(input logic [15:0] k);
    int l;
    run(0, 0, 0, 1, k, 0, l);
  endtask

  initial begin
    int len;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 cpu", cpu_rst_n, 1);
    chk("R1 mem", mem_rst_n, 1);
    dur = 4;
    run(1, 3, CMD, 0, 0, 0, len); chk("R1 locked after reset", len, 0);
    run(1, 3, 16'hFFFF, 0, 0, 0, len); chk("R3 locked ignored", len, 0);
    key(16'hA5C2);
    run(1, 3, CMD, 0, 0, 0, len); chk("R6 wrong key", len, 0);
    key(KEY);
    run(1, 3, 16'hBFFF, 0, 0, 0, len); chk("R2 bit14 zero", len, 0);
    for (int a = 0; a < 16; a++) begin
      if (a == 3) continue;
      run(1, 8'(a), CMD, 0, 0, 0, len); chk("R7 other address", len, 0);
    end
    for (int dv = 0; dv < 12; dv++) begin
      dur = 8'(dv);
      run(1, 3, CMD, 0, 0, 0, len);
      chk("R4 pulse length", len, (dv == 0) ? 1 : dv);
    end
    dur = 255;
    run(1, 3, CMD, 0, 0, 0, len); chk("R4 max length", len, 255);
    dur = 6;
    run(1, 3, CMD, 0, 0, 0, len); chk("R6 unlock persists", len, 6);
    for (int r = 1; r < 6; r++) begin
      dur = 6;
      run(1, 3, CMD, 0, 0, r, len); chk("R8 no retrigger", len, 6);
    end
    dur = 3;
    run(1, 3, CMD, 1, 16'h0000, 0, len); chk("R9 lock same cycle", len, 3);
    run(1, 3, CMD, 0, 0, 0, len); chk("R6 relocked", len, 0);
    run(1, 3, CMD, 1, KEY, 0, len); chk("R9 unlock same cycle", len, 0);
    run(1, 3, CMD, 0, 0, 0, len); chk("R9 unlocked after", len, 3);
    rst_n = 0; @(negedge clk); rst_n = 1; @(negedge clk);
    run(1, 3, CMD, 0, 0, 0, len); chk("R1 relock on reset", len, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule